// File: doc/BRIEF.md
# Buffered Serial Control Register Interface

This block is a three-wire serial slave that configures an integer-N frequency synthesizer. A host shifts 24-bit words into it on a serial clock and data line, then raises a load strobe. Each word holds twenty data bits followed by a four-bit address. The slave decodes the word into one of five control registers and drives the decoded fields out as parallel signals to the divider, charge-pump, lock-detect and general-purpose output logic.

Two of the registers are staged. The charge-pump current word and the reference/prescaler word go into shadow buffers when they are written. They reach the outputs only when the divider word (the swallow and program counts) is written. All three then change in the same cycle, so a frequency retune never runs with a mix of old and new settings. A one-cycle commit strobe marks each such update. The function word and the output-pin word take effect as soon as they are written. The serial lines are asynchronous to the system clock. They are synchronized and edge-detected before use.

Top module: `synth_ctrl_sif`

## Requirements
- R1: After reset every output field, both pins and the commit strobe are 0, and both shadow buffers are 0.
- R2: A word is accepted on the rising edge of the load line only if exactly 24 serial clock rising edges were seen since the previous load edge. Bits arrive MSB first. The first 20 bits are data bits 19 down to 0 and the last 4 bits are the address, MSB first.
- R3: Address 5 (0101) updates the pins at once: data bit 0 drives gpo1 and data bit 1 drives gpo2.
- R4: Address 4 (0100) updates at once: lock_sel from bits 18:17, fast_en from bit 16, cp_tristate from bit 15, cp_invert from bit 14, lock_mode from bit 13 and fast_cnt from bits 12:0.
- R5: Address 2 (0010) stores cp_fast (bits 9:6) and cp_norm (bits 3:0) in a shadow buffer. The cp_fast and cp_norm outputs do not change until the next address-1 commit.
- R6: Address 3 (0011) stores pre_sel (bits 15:14) and r_div (bits 13:0) in a shadow buffer. The pre_sel and r_div outputs do not change until the next address-1 commit.
- R7: Address 1 (0001) loads b_cnt from bits 18:6 and a_cnt from bits 5:0. In the same cycle it copies both shadow buffers to their outputs.
- R8: commit_stb is high for exactly one system clock on each address-1 commit, in the cycle the new values appear, and is low at all other times.
- R9: A word with any bit count other than 24 changes no output and produces no strobe.
- R10: A word whose address is not 1 to 5 changes no output and produces no strobe.
- R11: When a staged address is written more than once before a commit, the most recent value is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on ser_clk rise |
| ser_le | input | 1 | Load strobe, word taken on its rise |
| a_cnt | output | 6 | Swallow count |
| b_cnt | output | 13 | Program count |
| r_div | output | 14 | Reference divide ratio |
| pre_sel | output | 2 | Prescaler modulus code |
| cp_norm | output | 4 | Charge-pump current code, normal |
| cp_fast | output | 4 | Charge-pump current code, fast lock |
| lock_sel | output | 2 | Lock-detect count select |
| fast_en | output | 1 | Fast-lock enable |
| cp_tristate | output | 1 | Charge-pump high-impedance request |
| cp_invert | output | 1 | Charge-pump polarity |
| lock_mode | output | 1 | Lock-detect mode select |
| fast_cnt | output | 13 | Fast-lock duration count |
| gpo1 | output | 1 | General-purpose output 1 |
| gpo2 | output | 1 | General-purpose output 2 |
| commit_stb | output | 1 | One-cycle pulse on divider-word commit |

## Verification
The output-pin word is swept through all four values. This ties the bit order and address placement to a visible result. A sequence of pseudo-random function words shows that each field lands on its own output with no neighbour leaking in. Staged words are written and checked before and after the commit, which separates a design that stages from one that updates at once. Repeated staged writes before a commit show that the last value wins. Words of 23 and 25 bits and words with unused addresses show that malformed traffic is rejected. Divider words at the extreme counts check the field edges.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 20;
  localparam int WORD_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] ADR_AB   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CP   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_REF  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_FUNC = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_GPO  = 4'd5;

  typedef struct packed {
    logic [12:0] b;
    logic [5:0]  a;
  } ab_t;

  typedef struct packed {
    logic [3:0] fast;
    logic [3:0] norm;
  } cp_t;

  typedef struct packed {
    logic [1:0]  pre;
    logic [13:0] rdiv;
  } ref_t;

  typedef struct packed {
    logic [1:0]  lock_sel;
    logic        fast_en;
    logic        tri_st;
    logic        invert;
    logic        lock_mode;
    logic [12:0] fast;
  } func_t;

  function automatic logic addr_known(input logic [ADDR_W-1:0] ad);
    return (ad >= ADR_AB) && (ad <= ADR_GPO);
  endfunction

  function automatic ab_t dec_ab(input logic [DATA_W-1:0] d);
    ab_t r;
    r.b = d[18:6];
    r.a = d[5:0];
    return r;
  endfunction

  function automatic cp_t dec_cp(input logic [DATA_W-1:0] d);
    cp_t r;
    r.fast = d[9:6];
    r.norm = d[3:0];
    return r;
  endfunction

  function automatic ref_t dec_ref(input logic [DATA_W-1:0] d);
    ref_t r;
    r.pre  = d[15:14];
    r.rdiv = d[13:0];
    return r;
  endfunction

  function automatic func_t dec_func(input logic [DATA_W-1:0] d);
    func_t r;
    r.lock_sel  = d[18:17];
    r.fast_en   = d[16];
    r.tri_st    = d[15];
    r.invert    = d[14];
    r.lock_mode = d[13];
    r.fast      = d[12:0];
    return r;
  endfunction
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else if (i == 0) stg[i] <= din;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sif_shifter.sv
module sif_shifter
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              sle_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              sclk_d, sle_d;
  logic              sclk_rise, le_rise;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt_q;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign le_rise   = sle_s & ~sle_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sle_d  <= 1'b0;
      shreg  <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_d <= sclk_s;
      sle_d  <= sle_s;
      if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdata_s};
      if (le_rise) cnt_q <= '0;
      else if (sclk_rise && cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wr_addr = shreg[ADDR_W-1:0];
  assign wr_data = shreg[WORD_W-1:ADDR_W];
  assign wr_stb  = le_rise && (cnt_q == CNT_W'(WORD_W)) && addr_known(wr_addr);

  // R9: bit counter restarts after each load edge
  a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> (cnt_q == '0));
  // R9: counter saturates just past a full word
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/sif_regbank.sv
module sif_regbank
  import sif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ab_t               ab_q,
  output cp_t               cp_q,
  output ref_t              ref_q,
  output func_t             func_q,
  output logic [1:0]        gpo_q,
  output logic              stb_q
);
  cp_t  cp_sh;
  ref_t ref_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_sh  <= '0;
      ref_sh <= '0;
      ab_q   <= '0;
      cp_q   <= '0;
      ref_q  <= '0;
      func_q <= '0;
      gpo_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (wr_stb) begin
        case (wr_addr)
          ADR_AB: begin
            ab_q  <= dec_ab(wr_data);
            cp_q  <= cp_sh;
            ref_q <= ref_sh;
            stb_q <= 1'b1;
          end
          ADR_CP:   cp_sh  <= dec_cp(wr_data);
          ADR_REF:  ref_sh <= dec_ref(wr_data);
          ADR_FUNC: func_q <= dec_func(wr_data);
          ADR_GPO:  gpo_q  <= wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  a_r5_cp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(cp_q));
  a_r6_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(ref_q));
  a_r3_gpo_src: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpo_q) |-> $past(wr_stb && wr_addr == ADR_GPO));
  a_r4_func_src: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func_q) |-> $past(wr_stb && wr_addr == ADR_FUNC));
endmodule

// File: rtl/synth_ctrl_sif.sv
module synth_ctrl_sif
  import sif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  output logic [5:0]  a_cnt,
  output logic [12:0] b_cnt,
  output logic [13:0] r_div,
  output logic [1:0]  pre_sel,
  output logic [3:0]  cp_norm,
  output logic [3:0]  cp_fast,
  output logic [1:0]  lock_sel,
  output logic        fast_en,
  output logic        cp_tristate,
  output logic        cp_invert,
  output logic        lock_mode,
  output logic [12:0] fast_cnt,
  output logic        gpo1,
  output logic        gpo2,
  output logic        commit_stb
);
  logic [2:0]        ser_s;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  ab_t               ab_q;
  cp_t               cp_q;
  ref_t              ref_q;
  func_t             func_q;
  logic [1:0]        gpo_q;

  sif_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ser_le, ser_data, ser_clk}), .dout(ser_s)
  );

  sif_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(ser_s[0]), .sdata_s(ser_s[1]), .sle_s(ser_s[2]),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sif_regbank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .ab_q(ab_q), .cp_q(cp_q), .ref_q(ref_q), .func_q(func_q),
    .gpo_q(gpo_q), .stb_q(commit_stb)
  );

  assign a_cnt       = ab_q.a;
  assign b_cnt       = ab_q.b;
  assign r_div       = ref_q.rdiv;
  assign pre_sel     = ref_q.pre;
  assign cp_norm     = cp_q.norm;
  assign cp_fast     = cp_q.fast;
  assign lock_sel    = func_q.lock_sel;
  assign fast_en     = func_q.fast_en;
  assign cp_tristate = func_q.tri_st;
  assign cp_invert   = func_q.invert;
  assign lock_mode   = func_q.lock_mode;
  assign fast_cnt    = func_q.fast;
  assign gpo1        = gpo_q[0];
  assign gpo2        = gpo_q[1];
endmodule

// File: tb/synth_ctrl_sif_tb.sv
module synth_ctrl_sif_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [5:0] a_cnt; logic [12:0] b_cnt; logic [13:0] r_div; logic [1:0] pre_sel;
  logic [3:0] cp_norm, cp_fast; logic [1:0] lock_sel;
  logic fast_en, cp_tristate, cp_invert, lock_mode; logic [12:0] fast_cnt;
  logic gpo1, gpo2, commit_stb;

  int checks = 0, failures = 0;
  int stb_hi = 0, stb_rise = 0, exp_commits = 0;
  bit done = 0;
  logic stb_prev = 1'b0;

  // bench model of the outputs and shadow buffers
  int m_a = 0, m_b = 0, m_r = 0, m_pre = 0, m_cpn = 0, m_cpf = 0;
  int s_r = 0, s_pre = 0, s_cpn = 0, s_cpf = 0;
  int m_func = 0, m_gpo = 0;

  synth_ctrl_sif u_dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (commit_stb) stb_hi++;
    if (commit_stb && !stb_prev) stb_rise++;
    stb_prev <= commit_stb;
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk); ser_le = 1'b1;
    repeat (4) @(negedge clk); ser_le = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_word(input int addr, input int data);
    send_bits({8'd0, 20'(data), 4'(addr)}, 24);
  endtask

  task automatic check_all(input string req);
    check(req, "a_cnt", a_cnt, m_a);
    check(req, "b_cnt", b_cnt, m_b);
    check(req, "r_div", r_div, m_r);
    check(req, "pre_sel", pre_sel, m_pre);
    check(req, "cp_norm", cp_norm, m_cpn);
    check(req, "cp_fast", cp_fast, m_cpf);
    check(req, "lock_sel", lock_sel, (m_func >> 17) % 4);
    check(req, "fast_en", fast_en, (m_func >> 16) % 2);
    check(req, "cp_tristate", cp_tristate, (m_func >> 15) % 2);
    check(req, "cp_invert", cp_invert, (m_func >> 14) % 2);
    check(req, "lock_mode", lock_mode, (m_func >> 13) % 2);
    check(req, "fast_cnt", fast_cnt, m_func % 8192);
    check(req, "gpo1", gpo1, m_gpo % 2);
    check(req, "gpo2", gpo2, (m_gpo / 2) % 2);
    check(req, "strobe count", stb_rise, exp_commits);
    check(req, "strobe width", stb_hi, exp_commits);
  endtask

  task automatic wr_cp(input int d);
    send_word(2, d); s_cpf = (d / 64) % 16; s_cpn = d % 16;
  endtask
  task automatic wr_ref(input int d);
    send_word(3, d); s_pre = (d / 16384) % 4; s_r = d % 16384;
  endtask
  task automatic wr_ab(input int d);
    send_word(1, d);
    m_b = (d / 64) % 8192; m_a = d % 64;
    m_cpn = s_cpn; m_cpf = s_cpf; m_r = s_r; m_pre = s_pre;
    exp_commits++;
  endtask

  initial begin
    int lfsr = 20'hACE1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1");

    // R2/R3: every pin pattern, proves bit order and address placement
    for (int g = 0; g < 4; g++) begin
      send_word(5, 20'hFFFFC | g); m_gpo = g;
      check_all("R3");
    end

    // R4: pseudo-random function words
    for (int k = 0; k < 8; k++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 19) ^ (lfsr >> 16)) & 1)) % 1048576;
      send_word(4, lfsr); m_func = lfsr % 524288;
      check_all("R4");
    end

    // R5/R6 staging then R7 commit
    wr_cp(32'h3C5);  check_all("R5");
    wr_ref(32'hB123); check_all("R6");
    wr_ab((1234 << 6) | 17); check_all("R7");

    // R11: repeated staged writes, last wins
    for (int k = 0; k < 5; k++) begin
      wr_cp(k * 37 + 5);
      wr_cp((k * 91 + 200) % 1024);
      wr_ref((k * 12345 + 4) % 65536);
      wr_ref((k * 7919 + 40000) % 65536);
      check_all("R11");
      wr_ab((k * 100 + 3) * 64 + k * 11);
      check_all("R11");
    end

    // R7 field edges
    wr_ab((8191 << 6) | 63); check_all("R7");
    wr_ab(3 << 6);           check_all("R7");

    // R9: short and long words aimed at the pin register
    send_bits({8'd0, 20'h00003, 4'd5} >> 1, 23); check_all("R9");
    send_bits({7'd0, 1'b1, 20'h00002, 4'd5}, 25); check_all("R9");
    send_bits({8'd0, 20'h0F00F, 4'd1}, 24); // valid commit after malformed traffic
    m_b = 32'h0F00F / 64 % 8192; m_a = 32'h0F00F % 64;
    m_cpn = s_cpn; m_cpf = s_cpf; m_r = s_r; m_pre = s_pre; exp_commits++;
    check_all("R9");

    // R10: unknown addresses
    send_word(0, 20'hFFFFF);  check_all("R10");
    send_word(6, 20'h00003);  check_all("R10");
    send_word(15, 20'h12345); check_all("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule